// File: doc/BRIEF.md
# SECDED-Protected Packet FIFO

A synchronous first-in, first-out queue for packet beats. Each beat is a 64-bit data word plus an 18-bit control word (packet start, packet end, count of unused trailing bytes, an error flag and a 12-bit sideband). On the way in, each of the two fields is wrapped in its own extended Hamming codeword before it is written to storage. On the way out, each field is checked on its own. A single flipped bit in either field is repaired without the consumer seeing it. A double flip is reported, and a small state machine on the read side turns it into a packet-level outcome.

When the damaged field is data, the beat is still delivered, and the error flag is forced on the closing beat of that packet. When the damaged field is control, the packet boundaries in that beat can no longer be trusted. The beat is then discarded. The state machine either marks the open packet bad or skips beats until the framing settles. If a start marker turns up inside an open packet, the two packets are merged into one bad packet. Three one-cycle status pulses and three saturating event counters report corrected errors, uncorrectable errors and lost packet boundaries. An injection port lets a test flip chosen codeword bits on the next accepted write.

The read-side state machine has four states:
- `S_IDLE`: between packets.
- `S_GOOD`: inside a clean packet.
- `S_BAD`: inside a packet that will close with its error flag set.
- `S_SKIP`: discarding beats that lost their start.

It has these transitions:
- `S_IDLE`/`S_SKIP` go to `S_GOOD` or `S_BAD` on a start beat without an end marker.
- `S_IDLE`/`S_SKIP` go to `S_SKIP` on a beat whose control word cannot be decoded, or on a non-start beat without an end marker.
- `S_SKIP` goes to `S_IDLE` on a discarded end beat.
- `S_GOOD` goes to `S_BAD` on a data double error, a control double error or a merged start.
- `S_GOOD`/`S_BAD` go to `S_IDLE` on an accepted end beat.

Top module: `secded_pkt_fifo`

## Requirements
- R1: Beats leave in write order. `in_ready` equals not-`full`. `full` rises when DEPTH (16) beats are held and `empty` when none are. A beat is taken on `in_valid && in_ready` and delivered on `out_valid && out_ready`. `out_valid` does not depend on `out_ready`.
- R2: While `rst_n` is low at a clock edge, the queue empties, the state machine returns to idle, and all pulses and counters read zero.
- R3: A data codeword is 72 bits: bit 0 is overall parity, positions 1..71 form a Hamming code with check bits at powers of two, and the data bits fill the other positions in ascending order. A control codeword is 24 bits, built the same way over positions 1..23. In the control word, bit 0 = start, bit 1 = end, bits 4:2 = empty count, bit 5 = error, bits 17:6 = sideband. A flip of any one bit of either codeword, parity bits included, is corrected.
- R4: When a beat is consumed (delivered or discarded) with one flipped bit in either field, its fields come out intact and `ecc_sbe` is high for exactly the next cycle.
- R5: When a consumed beat has two flipped bits in either field, `ecc_mbe` is high for the next cycle. A data double error leaves the beat delivered and forces `out_err` on that packet's end beat.
- R6: A beat whose control field has two flipped bits is never presented. Inside a packet, the packet continues and closes with `out_err` set.
- R7: A start beat arriving inside an open packet is delivered with `out_sop` low and merged into the open packet, which closes with `out_err` set. `pkt_drop` pulses on the cycle after that beat is accepted.
- R8: Outside a packet, a non-start beat or an undecodable control field causes a discard, and `pkt_drop` pulses once. Later non-start beats are discarded silently until an end beat or a new start beat. Discards need no `out_ready`.
- R9: `inj_load` arms two masks. Each set bit flips the matching codeword bit of the next accepted write only, after which the masks clear. If a load coincides with a write, that write uses the previously armed masks.
- R10: The counters `cnt_corr`, `cnt_uncorr` and `cnt_drop` (CNT_W bits, 32 by default) count `ecc_sbe`, `ecc_mbe` and `pkt_drop` events in the same cycle as the pulse. They stop at all-ones and clear on `cnt_clear`.
- R11: While `out_valid` is high and `out_ready` low, the presented beat stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Write beat offered |
| in_ready | output | 1 | Queue can take a beat |
| in_data | input | 64 | Write data word |
| in_sop | input | 1 | Write beat starts a packet |
| in_eop | input | 1 | Write beat ends a packet |
| in_empty | input | 3 | Unused bytes in end beat |
| in_err | input | 1 | Error flag carried with beat |
| in_side | input | 12 | Sideband carried with beat |
| out_valid | output | 1 | Read beat presented |
| out_ready | input | 1 | Consumer takes beat |
| out_data | output | 64 | Corrected data word |
| out_sop | output | 1 | Packet start |
| out_eop | output | 1 | Packet end |
| out_empty | output | 3 | Unused bytes in end beat |
| out_err | output | 1 | Packet error flag |
| out_side | output | 12 | Sideband |
| full | output | 1 | Storage full |
| empty | output | 1 | Storage empty |
| inj_load | input | 1 | Arm injection masks |
| inj_data_mask | input | 72 | Data codeword flip mask |
| inj_ctrl_mask | input | 24 | Control codeword flip mask |
| ecc_sbe | output | 1 | Corrected error pulse |
| ecc_mbe | output | 1 | Uncorrectable error pulse |
| pkt_drop | output | 1 | Lost packet boundary pulse |
| cnt_clear | input | 1 | Clear all counters |
| cnt_corr | output | CNT_W | Corrected error count |
| cnt_uncorr | output | CNT_W | Uncorrectable error count |
| cnt_drop | output | CNT_W | Lost boundary count |

## Verification
A correction and an uncorrectable report can come from the same beat: one field carries one flip while the other carries two. The bench arms exactly such a mixed mask. It expects `ecc_sbe` and `ecc_mbe` together, and it expects both counters to advance in the same cycle. A second collision is a control double error on a beat seen from idle, which must raise `ecc_mbe` and `pkt_drop` together. A behavioural queue model predicts every port on every cycle, so any cycle in which only one of the two events appears is caught.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int CTRL_W = 18;

    typedef struct packed {
        logic [11:0] side;
        logic        err;
        logic [2:0]  empty;
        logic        eop;
        logic        sop;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_GOOD,
        S_BAD,
        S_SKIP
    } pkt_state_e;

    // number of Hamming check bits needed for k payload bits
    function automatic int hbits(input int k);
        int r;
        r = 1;
        while ((1 << r) < k + r + 1) r++;
        return r;
    endfunction

endpackage

// File: rtl/spf_secded_enc.sv
module spf_secded_enc
    import spf_pkg::*;
#(
    parameter int DW = 64,
    localparam int PW = hbits(DW),
    localparam int NW = DW + PW
) (
    input  logic [DW-1:0] data,
    output logic [NW:0]   code
);

    function automatic logic [NW:0] enc(input logic [DW-1:0] d);
        logic [NW:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= NW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j++;
            end
        end
        for (int i = 0; i < PW; i++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p <= NW; p++) begin
                if (((p >> i) & 1) == 1 && p != (1 << i)) x ^= c[p];
            end
            c[1 << i] = x;
        end
        c[0] = ^c[NW:1];
        return c;
    endfunction

    assign code = enc(data);

endmodule

// File: rtl/spf_secded_dec.sv
module spf_secded_dec
    import spf_pkg::*;
#(
    parameter int DW = 64,
    localparam int PW = hbits(DW),
    localparam int NW = DW + PW
) (
    input  logic [NW:0]   code,
    output logic [DW-1:0] data,
    output logic          corrected,
    output logic          uncorrectable
);

    function automatic logic [PW-1:0] syn(input logic [NW:0] c);
        logic [PW-1:0] s;
        s = '0;
        for (int p = 1; p <= NW; p++) begin
            if (c[p]) s ^= PW'(p);
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] extract(input logic [NW:0] c);
        logic [DW-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= NW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = c[p];
                j++;
            end
        end
        return d;
    endfunction

    logic [PW-1:0] s;
    logic          par;
    logic          in_range;
    logic [NW:0]   fixed;

    always_comb begin
        s        = syn(code);
        par      = ^code;
        in_range = (int'(s) <= NW);
        fixed    = code;
        if (s != '0 && par && in_range) fixed[s] = ~fixed[s];
    end

    assign data          = extract(fixed);
    assign corrected     = par && (s == '0 || in_range);
    assign uncorrectable = (s != '0 && !par) || (par && !in_range);

endmodule

// File: rtl/spf_pkt_guard.sv
module spf_pkt_guard
    import spf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  head_valid,
    input  ctrl_t head_c,
    input  logic  c_unc,
    input  logic  d_unc,
    input  logic  out_ready,
    output logic  fwd,
    output logic  pop,
    output logic  sop_o,
    output logic  err_o,
    output logic  drop_evt
);

    pkt_state_e st, nxt;
    logic       discard;
    logic       mark;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        fwd      = 1'b0;
        discard  = 1'b0;
        drop_evt = 1'b0;
        mark     = 1'b0;
        sop_o    = head_c.sop;
        if (head_valid) begin
            unique case (st)
                S_IDLE, S_SKIP: begin
                    if (c_unc) begin
                        discard  = 1'b1;
                        drop_evt = (st == S_IDLE);
                        nxt      = S_SKIP;
                    end else if (head_c.sop) begin
                        fwd  = 1'b1;
                        mark = d_unc;
                        if (out_ready)
                            nxt = head_c.eop ? S_IDLE : (d_unc ? S_BAD : S_GOOD);
                    end else begin
                        discard  = 1'b1;
                        drop_evt = (st == S_IDLE);
                        nxt      = head_c.eop ? S_IDLE : S_SKIP;
                    end
                end
                S_GOOD, S_BAD: begin
                    if (c_unc) begin
                        discard = 1'b1;
                        nxt     = S_BAD;
                    end else begin
                        fwd      = 1'b1;
                        sop_o    = 1'b0;
                        mark     = (st == S_BAD) || d_unc || head_c.sop;
                        drop_evt = head_c.sop && out_ready;
                        if (out_ready)
                            nxt = head_c.eop ? S_IDLE : (mark ? S_BAD : S_GOOD);
                    end
                end
            endcase
        end
        pop   = discard || (fwd && out_ready);
        err_o = head_c.err || (mark && head_c.eop);
    end

endmodule

// File: rtl/spf_sat_counter.sv
module spf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)             value <= '0;
        else if (inc && value != '1)   value <= value + 1'b1;
    end

endmodule

// File: rtl/secded_pkt_fifo.sv
module secded_pkt_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int DCW   = DATA_W + hbits(DATA_W) + 1,
    localparam int CCW   = CTRL_W + hbits(CTRL_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [2:0]        in_empty,
    input  logic              in_err,
    input  logic [11:0]       in_side,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [2:0]        out_empty,
    output logic              out_err,
    output logic [11:0]       out_side,
    output logic              full,
    output logic              empty,
    input  logic              inj_load,
    input  logic [DCW-1:0]    inj_data_mask,
    input  logic [CCW-1:0]    inj_ctrl_mask,
    output logic              ecc_sbe,
    output logic              ecc_mbe,
    output logic              pkt_drop,
    input  logic              cnt_clear,
    output logic [CNT_W-1:0]  cnt_corr,
    output logic [CNT_W-1:0]  cnt_uncorr,
    output logic [CNT_W-1:0]  cnt_drop
);

    logic [DCW-1:0] dmem [DEPTH];
    logic [CCW-1:0] cmem [DEPTH];
    logic [AW:0]    wptr, rptr;
    logic [DCW-1:0] arm_d, enc_d;
    logic [CCW-1:0] arm_c, enc_c;
    ctrl_t          wr_c, head_c;
    logic [CTRL_W-1:0] head_raw;
    logic           wr, pop, fwd, drop_evt;
    logic           d_cor, d_unc, c_cor, c_unc;
    logic           sop_o, err_o;
    logic [2:0]     evt;
    logic [CNT_W-1:0] cnt_q [3];

    assign empty    = (wptr == rptr);
    assign full     = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign in_ready = !full;
    assign wr       = in_valid && in_ready;

    assign wr_c = '{side: in_side, err: in_err, empty: in_empty, eop: in_eop, sop: in_sop};

    spf_secded_enc #(.DW(DATA_W)) u_enc_d (.data(in_data), .code(enc_d));
    spf_secded_enc #(.DW(CTRL_W)) u_enc_c (.data(wr_c),    .code(enc_c));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_d <= '0;
            arm_c <= '0;
        end else if (inj_load) begin
            arm_d <= inj_data_mask;
            arm_c <= inj_ctrl_mask;
        end else if (wr) begin
            arm_d <= '0;
            arm_c <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            dmem[wptr[AW-1:0]] <= enc_d ^ arm_d;
            cmem[wptr[AW-1:0]] <= enc_c ^ arm_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr)  wptr <= wptr + 1'b1;
            if (pop) rptr <= rptr + 1'b1;
        end
    end

    spf_secded_dec #(.DW(DATA_W)) u_dec_d (
        .code(dmem[rptr[AW-1:0]]), .data(out_data),
        .corrected(d_cor), .uncorrectable(d_unc)
    );
    spf_secded_dec #(.DW(CTRL_W)) u_dec_c (
        .code(cmem[rptr[AW-1:0]]), .data(head_raw),
        .corrected(c_cor), .uncorrectable(c_unc)
    );
    assign head_c = ctrl_t'(head_raw);

    spf_pkt_guard u_guard (
        .clk(clk), .rst_n(rst_n), .head_valid(!empty), .head_c(head_c),
        .c_unc(c_unc), .d_unc(d_unc), .out_ready(out_ready),
        .fwd(fwd), .pop(pop), .sop_o(sop_o), .err_o(err_o), .drop_evt(drop_evt)
    );

    assign out_valid = fwd;
    assign out_sop   = sop_o;
    assign out_eop   = head_c.eop;
    assign out_empty = head_c.empty;
    assign out_err   = err_o;
    assign out_side  = head_c.side;

    assign evt = {drop_evt, pop && (d_unc || c_unc), pop && (d_cor || c_cor)};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_sbe  <= 1'b0;
            ecc_mbe  <= 1'b0;
            pkt_drop <= 1'b0;
        end else begin
            ecc_sbe  <= evt[0];
            ecc_mbe  <= evt[1];
            pkt_drop <= evt[2];
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_cnt
        spf_sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clear),
            .inc(evt[g]), .value(cnt_q[g])
        );
    end

    assign cnt_corr   = cnt_q[0];
    assign cnt_uncorr = cnt_q[1];
    assign cnt_drop   = cnt_q[2];

endmodule

// File: rtl/spf_chk.sv
module spf_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full,
    input logic             empty,
    input logic             out_valid,
    input logic             out_ready,
    input logic [63:0]      out_data,
    input logic             out_eop,
    input logic             out_sop,
    input logic             ecc_sbe,
    input logic             ecc_mbe,
    input logic             pkt_drop,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] cnt_corr,
    input logic [CNT_W-1:0] cnt_uncorr,
    input logic [CNT_W-1:0] cnt_drop
);

    // R1
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R1
    valid_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !empty);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_eop) && $stable(out_sop)));

    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !out_valid && !ecc_sbe && !ecc_mbe && !pkt_drop
                    && cnt_corr == '0 && cnt_uncorr == '0 && cnt_drop == '0));

    // R10
    corr_tracks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && cnt_corr != '1)
        |=> cnt_corr == $past(cnt_corr) + {{(CNT_W-1){1'b0}}, ecc_sbe});

    // R10
    uncorr_tracks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && cnt_uncorr != '1)
        |=> cnt_uncorr == $past(cnt_uncorr) + {{(CNT_W-1){1'b0}}, ecc_mbe});

    // R10
    drop_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && cnt_drop == '1) |=> cnt_drop == '1);

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (cnt_corr == '0 && cnt_uncorr == '0 && cnt_drop == '0));

endmodule

bind secded_pkt_fifo spf_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .full(full), .empty(empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eop(out_eop), .out_sop(out_sop),
    .ecc_sbe(ecc_sbe), .ecc_mbe(ecc_mbe), .pkt_drop(pkt_drop),
    .cnt_clear(cnt_clear), .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr),
    .cnt_drop(cnt_drop)
);

// File: tb/test_secded_pkt_fifo.sv
module test_secded_pkt_fifo;

    localparam int DEPTH = 16;
    localparam int CW    = 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, in_valid, in_sop, in_eop, in_err, out_ready, inj_load, cnt_clear;
    logic [63:0] in_data;
    logic [2:0]  in_empty;
    logic [11:0] in_side;
    logic [71:0] inj_data_mask;
    logic [23:0] inj_ctrl_mask;
    logic in_ready, out_valid, out_sop, out_eop, out_err, full, empty;
    logic ecc_sbe, ecc_mbe, pkt_drop;
    logic [63:0] out_data;
    logic [2:0]  out_empty;
    logic [11:0] out_side;
    logic [CW-1:0] cnt_corr, cnt_uncorr, cnt_drop;

    secded_pkt_fifo #(.DEPTH(DEPTH), .CNT_W(CW)) i_secded_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .in_err(in_err), .in_side(in_side), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err),
        .out_side(out_side), .full(full), .empty(empty), .inj_load(inj_load),
        .inj_data_mask(inj_data_mask), .inj_ctrl_mask(inj_ctrl_mask),
        .ecc_sbe(ecc_sbe), .ecc_mbe(ecc_mbe), .pkt_drop(pkt_drop),
        .cnt_clear(cnt_clear), .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr),
        .cnt_drop(cnt_drop)
    );

    typedef struct {
        logic [63:0] d;
        logic [17:0] c;
        int df;
        int cf;
    } ent_t;

    ent_t q[$];
    int mst;             // 0 idle, 1 good, 2 bad, 3 skip
    bit e_sbe, e_mbe, e_drop;
    int ec[3];
    int arm_df, arm_cf;
    int n_chk, n_fail;
    string cur;
    bit done;
    bit m_fwd, m_disc, m_drop, m_sop, m_err;
    int m_next;

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", cur, what, act, exp);
        end
    endtask

    function automatic void decide();
        ent_t h;
        bit cd, dd, s, e, bad;
        m_fwd = 0; m_disc = 0; m_drop = 0; m_sop = 0; m_err = 0; m_next = mst;
        if (q.size() == 0) return;
        h = q[0];
        cd = (h.cf == 2); dd = (h.df == 2); s = h.c[0]; e = h.c[1]; bad = 0;
        if (mst == 0 || mst == 3) begin
            if (cd) begin
                m_disc = 1; m_drop = (mst == 0); m_next = 3;
            end else if (s) begin
                m_fwd = 1; m_sop = 1; bad = dd;
                if (out_ready) m_next = e ? 0 : (dd ? 2 : 1);
            end else begin
                m_disc = 1; m_drop = (mst == 0); m_next = e ? 0 : 3;
            end
        end else begin
            if (cd) begin
                m_disc = 1; m_next = 2;
            end else begin
                m_fwd = 1; m_sop = 0; bad = (mst == 2) || dd || s;
                m_drop = s && out_ready;
                if (out_ready) m_next = e ? 0 : (bad ? 2 : 1);
            end
        end
        m_err = h.c[5] || (bad && e);
    endfunction

    task automatic step();
        ent_t h;
        bit pop, acc;
        #1;
        decide();
        chk(empty === (q.size() == 0), "empty", empty, q.size() == 0);
        chk(full === (q.size() == DEPTH), "full", full, q.size() == DEPTH);
        chk(in_ready === (q.size() != DEPTH), "in_ready", in_ready, q.size() != DEPTH);
        chk(out_valid === m_fwd, "out_valid", out_valid, m_fwd);
        if (m_fwd) begin
            h = q[0];
            chk(out_sop === m_sop, "out_sop", out_sop, m_sop);
            chk(out_eop === h.c[1], "out_eop", out_eop, h.c[1]);
            chk(out_err === m_err, "out_err", out_err, m_err);
            chk(out_empty === h.c[4:2], "out_empty", out_empty, h.c[4:2]);
            chk(out_side === h.c[17:6], "out_side", out_side, h.c[17:6]);
            if (h.df != 2) chk(out_data === h.d, "out_data", out_data, h.d);
        end
        chk(ecc_sbe === e_sbe, "ecc_sbe", ecc_sbe, e_sbe);
        chk(ecc_mbe === e_mbe, "ecc_mbe", ecc_mbe, e_mbe);
        chk(pkt_drop === e_drop, "pkt_drop", pkt_drop, e_drop);
        chk(cnt_corr == ec[0], "cnt_corr", cnt_corr, ec[0]);
        chk(cnt_uncorr == ec[1], "cnt_uncorr", cnt_uncorr, ec[1]);
        chk(cnt_drop == ec[2], "cnt_drop", cnt_drop, ec[2]);
        if (!rst_n) begin
            q.delete(); mst = 0; e_sbe = 0; e_mbe = 0; e_drop = 0;
            ec[0] = 0; ec[1] = 0; ec[2] = 0; arm_df = 0; arm_cf = 0;
        end else begin
            acc = in_valid && (q.size() != DEPTH);
            pop = m_disc || (m_fwd && out_ready);
            if (q.size() != 0) h = q[0];
            e_sbe  = pop && (h.df == 1 || h.cf == 1);
            e_mbe  = pop && (h.df == 2 || h.cf == 2);
            e_drop = m_drop;
            for (int i = 0; i < 3; i++) begin
                bit ev;
                ev = (i == 0) ? e_sbe : (i == 1) ? e_mbe : e_drop;
                if (cnt_clear) ec[i] = 0;
                else if (ev && ec[i] < CMAX) ec[i]++;
            end
            if (pop) void'(q.pop_front());
            mst = m_next;
            if (acc) begin
                ent_t n;
                n.d = in_data;
                n.c = {in_side, in_err, in_empty, in_eop, in_sop};
                n.df = arm_df; n.cf = arm_cf;
                q.push_back(n);
                arm_df = 0; arm_cf = 0;
            end
            if (inj_load) begin
                arm_df = $countones(inj_data_mask);
                arm_cf = $countones(inj_ctrl_mask);
            end
        end
        @(negedge clk);
    endtask

    task automatic put(bit s, bit e, logic [11:0] side);
        in_valid = 1; in_sop = s; in_eop = e; in_side = side;
        in_empty = e ? 3'(side[2:0]) : 3'd0; in_err = 0;
        in_data = {$urandom, $urandom};
        forever begin
            bit ok;
            ok = (q.size() != DEPTH);
            step();
            if (ok) break;
        end
        in_valid = 0;
    endtask

    task automatic arm(logic [71:0] dm, logic [23:0] cm);
        inj_load = 1; inj_data_mask = dm; inj_ctrl_mask = cm;
        step();
        inj_load = 0; inj_data_mask = '0; inj_ctrl_mask = '0;
    endtask

    task automatic pkt(int beats, logic [11:0] side);
        for (int b = 0; b < beats; b++) put(b == 0, b == beats - 1, side + 12'(b));
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0; in_empty = 0;
        in_side = 0; in_data = 0; out_ready = 1; inj_load = 0; cnt_clear = 0;
        inj_data_mask = '0; inj_ctrl_mask = '0;
        @(negedge clk);
        cur = "R2";
        idle(3);
        rst_n = 1;

        // R1: plain traffic, then fill to full and drain with a gappy consumer
        cur = "R1";
        pkt(3, 12'h100); pkt(1, 12'h110); pkt(5, 12'h120);
        idle(4);
        out_ready = 0;
        in_valid = 1;
        for (int i = 0; i < 20; i++) begin
            in_sop = 1; in_eop = 1; in_side = 12'(i); in_empty = 3'(i);
            in_data = {$urandom, $urandom};
            step();
        end
        in_valid = 0;
        // R11: held beat must not move while consumer stalls
        cur = "R11";
        for (int i = 0; i < 40; i++) begin
            out_ready = (i % 3) != 0;
            step();
        end
        out_ready = 1;

        // R3 / R4: every single-bit position of both codewords is repaired
        cur = "R3";
        for (int k = 0; k < 72; k++) begin
            arm(72'd1 << k, '0);
            pkt(1, 12'(k));
        end
        for (int k = 0; k < 24; k++) begin
            arm('0, 24'd1 << k);
            pkt(1, 12'(k + 12'h200));
        end
        idle(3);
        cur = "R4";
        cnt_clear = 1; step(); cnt_clear = 0;
        put(1, 0, 12'h300); arm(72'd1 << 33, '0); put(0, 0, 12'h301);
        arm('0, 24'd1 << 7); put(0, 1, 12'h302);
        idle(4);

        // R5: data double error mid-packet, eop carries the error
        cur = "R5";
        put(1, 0, 12'h400); arm((72'd1 << 10) | (72'd1 << 40), '0);
        put(0, 0, 12'h401); put(0, 1, 12'h402);
        arm((72'd1 << 0) | (72'd1 << 3), '0); pkt(1, 12'h403);
        pkt(2, 12'h404);
        idle(4);

        // R6: control double error on a middle beat
        cur = "R6";
        put(1, 0, 12'h500); arm('0, (24'd1 << 3) | (24'd1 << 9));
        put(0, 0, 12'h501); put(0, 1, 12'h502);
        idle(4);

        // R7: lost end marker merges two packets; then an explicit early start
        cur = "R7";
        put(1, 0, 12'h600); put(0, 0, 12'h601);
        arm('0, (24'd1 << 1) | (24'd1 << 20)); put(0, 1, 12'h602);
        pkt(3, 12'h610);
        put(1, 0, 12'h620); pkt(2, 12'h621);
        idle(4);

        // R8: lost start marker skips to the next frame; orphan beats
        cur = "R8";
        arm('0, (24'd1 << 0) | (24'd1 << 5)); put(1, 0, 12'h700);
        put(0, 0, 12'h701); put(0, 1, 12'h702);
        pkt(2, 12'h710);
        put(0, 0, 12'h720); put(0, 0, 12'h721); put(0, 1, 12'h722);
        put(0, 1, 12'h730);
        arm('0, (24'd1 << 2) | (24'd1 << 11)); put(1, 0, 12'h740);
        pkt(2, 12'h750);
        out_ready = 0;
        put(0, 0, 12'h760); put(0, 1, 12'h761);
        idle(3);
        out_ready = 1;
        idle(3);

        // R5 with R4: single flip in one field, double in the other, same beat
        cur = "R5";
        arm(72'd1 << 20, (24'd1 << 4) | (24'd1 << 6)); put(1, 1, 12'h780);
        put(1, 0, 12'h790); arm(72'd1 << 50, '0); put(0, 0, 12'h791);
        arm((72'd1 << 13) | (72'd1 << 66), 24'd1 << 15); put(0, 1, 12'h792);
        idle(4);

        // R9: masks hit one write only; load coinciding with a write
        cur = "R9";
        arm((72'd1 << 8) | (72'd1 << 9), '0);
        pkt(1, 12'h800); pkt(1, 12'h801);
        in_valid = 1; in_sop = 1; in_eop = 1; in_side = 12'h802; in_data = {$urandom, $urandom};
        inj_load = 1; inj_data_mask = 72'd1 << 30;
        step();
        inj_load = 0; inj_data_mask = '0; in_valid = 0;
        pkt(1, 12'h803); pkt(1, 12'h804);
        idle(4);

        // R10: saturation and clear
        cur = "R10";
        cnt_clear = 1; step(); cnt_clear = 0;
        for (int i = 0; i < 10; i++) begin
            arm(72'd1 << (i + 1), '0);
            pkt(1, 12'(12'h900 + i));
        end
        for (int i = 0; i < 9; i++) put(0, 1, 12'(12'h920 + i));
        idle(4);
        cnt_clear = 1; step(); cnt_clear = 0;
        idle(3);

        cur = "R2";
        pkt(4, 12'hA00);
        rst_n = 0; idle(2); rst_n = 1; idle(3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule